// File: doc/BRIEF.md
# Reciprocal-Multiply Quotient Unit

This block divides a stream of unsigned W-bit dividends by one fixed divisor d greater than one. It does this without a divider. The divisor is supplied as a precomputed double-width reciprocal C = ceil(2^(2W)/d), split into a high word and a low word and written through a load port.

Each dividend n is multiplied by both reciprocal words. Only the upper word of n times the low word is kept. That upper word is added to the full double-width product of n and the high word. The upper word of this sum is the quotient floor(n/d). Because the scale is exactly 2^(2W), no shift and no divisor-dependent correction follows the sum.

The pipeline accepts one dividend every cycle, and each quotient appears a fixed three cycles after its dividend. The reciprocal is copied into the pipeline together with each dividend. A new reciprocal may therefore be loaded while earlier dividends are still in flight.

Top module: `recip_quot_unit`

## Requirements
- R1: With C = ceil(2^(2W)/d) loaded and d > 1, every valid dividend n yields quotient_o = floor(n/d).
- R2: out_valid_o is in_valid_i delayed by exactly 3 clock cycles, and each quotient leaves in the same order its dividend entered.
- R3: Dividends presented on consecutive cycles are all accepted and produce quotients on consecutive cycles.
- R4: The carry out of the lower word of the internal sum reaches the quotient word. For example, n = 2^W-1 divided by 7 and by 10 gives the exact quotient.
- R5: A dividend presented in the same cycle as recip_load_i uses the newly loaded reciprocal. Dividends presented earlier keep the reciprocal that was active when they entered.
- R6: While recip_load_i is low, the stored reciprocal keeps its value.
- R7: After rst_ni is released, out_valid_o is 0 and quotient_o is 0 until the first result arrives.
- R8: In any cycle where out_valid_o is 0, quotient_o keeps its previous value.
- R9: A dividend of 0 yields a quotient of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| recip_load_i | input | 1 | Write the reciprocal words |
| recip_hi_i | input | W | Upper word of C |
| recip_lo_i | input | W | Lower word of C |
| in_valid_i | input | 1 | Dividend valid |
| dividend_i | input | W | Dividend n |
| out_valid_o | output | 1 | Quotient valid |
| quotient_o | output | W | floor(n/d) |

## Verification
Two events can fall in the same cycle: a reciprocal load and the issue of a dividend. The bench provokes this by streaming dividends back to back under one divisor. It then raises the load and a valid dividend together, and keeps the stream running under the new divisor. The scoreboard computes each expectation as n/d using the divisor in force when that dividend was driven. The dividends in flight must match the old divisor, and the dividend issued with the load must match the new one.

// File: rtl/rqu_pkg.sv
package rqu_pkg;
  localparam int unsigned DEF_W   = 32;
  localparam int unsigned LATENCY = 3;
endpackage

// File: rtl/rqu_recip_reg.sv
module rqu_recip_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic [W-1:0] hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load_i) begin
      hi_q <= hi_i;
      lo_q <= lo_i;
    end
  end

  // forward a same-cycle load to the issuing dividend
  assign hi_o = load_i ? hi_i : hi_q;
  assign lo_o = load_i ? lo_i : lo_q;
endmodule

// File: rtl/rqu_mul_stage.sv
module rqu_mul_stage #(
  parameter int unsigned W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [W-1:0]   n_i,
  input  logic [W-1:0]   c_hi_i,
  input  logic [W-1:0]   c_lo_i,
  output logic           valid_o,
  output logic [W-1:0]   lo_top_o,
  output logic [2*W-1:0] hi_prod_o
);
  localparam int unsigned PW = 2 * W;

  // issue stage: dividend tagged with its reciprocal
  logic         v0_q;
  logic [W-1:0] n0_q, chi0_q, clo0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v0_q   <= 1'b0;
      n0_q   <= '0;
      chi0_q <= '0;
      clo0_q <= '0;
    end else begin
      v0_q <= valid_i;
      if (valid_i) begin
        n0_q   <= n_i;
        chi0_q <= c_hi_i;
        clo0_q <= c_lo_i;
      end
    end
  end

  logic [PW-1:0] n_ext, p_hi;
  logic [W-1:0]  p_lo_top;

  always_comb begin
    n_ext    = {{W{1'b0}}, n0_q};
    p_hi     = n_ext * {{W{1'b0}}, chi0_q};
    // low word of n*Cl is dropped
    p_lo_top = W'((n_ext * {{W{1'b0}}, clo0_q}) >> W);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      lo_top_o  <= '0;
      hi_prod_o <= '0;
    end else begin
      valid_o <= v0_q;
      if (v0_q) begin
        lo_top_o  <= p_lo_top;
        hi_prod_o <= p_hi;
      end
    end
  end
endmodule

// File: rtl/rqu_sum_stage.sv
module rqu_sum_stage #(
  parameter int unsigned W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [W-1:0]   lo_top_i,
  input  logic [2*W-1:0] hi_prod_i,
  output logic           valid_o,
  output logic [W-1:0]   q_o
);
  logic [2*W-1:0] sum;

  // full-width add so the low-half carry reaches the quotient word
  assign sum = hi_prod_i + {{W{1'b0}}, lo_top_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) q_o <= sum[2*W-1:W];
    end
  end
endmodule

// File: rtl/recip_quot_unit.sv
module recip_quot_unit #(
  parameter int unsigned W = rqu_pkg::DEF_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         recip_load_i,
  input  logic [W-1:0] recip_hi_i,
  input  logic [W-1:0] recip_lo_i,
  input  logic         in_valid_i,
  input  logic [W-1:0] dividend_i,
  output logic         out_valid_o,
  output logic [W-1:0] quotient_o
);
  logic [W-1:0]   c_hi, c_lo;
  logic           mul_valid;
  logic [W-1:0]   lo_top;
  logic [2*W-1:0] hi_prod;

  rqu_recip_reg #(.W(W)) u_recip (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(recip_load_i),
    .hi_i  (recip_hi_i),
    .lo_i  (recip_lo_i),
    .hi_o  (c_hi),
    .lo_o  (c_lo)
  );

  rqu_mul_stage #(.W(W)) u_mul (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (in_valid_i),
    .n_i      (dividend_i),
    .c_hi_i   (c_hi),
    .c_lo_i   (c_lo),
    .valid_o  (mul_valid),
    .lo_top_o (lo_top),
    .hi_prod_o(hi_prod)
  );

  rqu_sum_stage #(.W(W)) u_sum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (mul_valid),
    .lo_top_i (lo_top),
    .hi_prod_i(hi_prod),
    .valid_o  (out_valid_o),
    .q_o      (quotient_o)
  );
endmodule

// File: rtl/rqu_checker.sv
module rqu_checker #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         recip_load_i,
  input logic         in_valid_i,
  input logic [W-1:0] dividend_i,
  input logic         out_valid_o,
  input logic [W-1:0] quotient_o,
  input logic [W-1:0] c_hi_q,
  input logic [W-1:0] c_lo_q
);
  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) |-> (out_valid_o == $past(in_valid_i, 3))); // R2

  AST_Q_NOT_ABOVE_N: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3 && out_valid_o) |-> (quotient_o <= $past(dividend_i, 3))); // R1

  AST_ZERO_DIVIDEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3 && $past(in_valid_i && dividend_i == '0, 3)) |-> (quotient_o == '0)); // R9

  AST_RECIP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !recip_load_i |=> ($stable(c_hi_q) && $stable(c_lo_q))); // R6

  AST_Q_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(quotient_o)); // R8
endmodule

bind recip_quot_unit rqu_checker #(.W(W)) i_rqu_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .recip_load_i(recip_load_i),
  .in_valid_i  (in_valid_i),
  .dividend_i  (dividend_i),
  .out_valid_o (out_valid_o),
  .quotient_o  (quotient_o),
  .c_hi_q      (u_recip.hi_q),
  .c_lo_q      (u_recip.lo_q)
);

// File: tb/test_recip_quot_unit.sv
module test_recip_quot_unit;
  localparam int unsigned W = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         recip_load_i = 1'b0;
  logic [W-1:0] recip_hi_i = '0;
  logic [W-1:0] recip_lo_i = '0;
  logic         in_valid_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic         out_valid_o;
  logic [W-1:0] quotient_o;

  always #10 clk_i = ~clk_i;

  recip_quot_unit #(.W(W)) i_recip_quot_unit (.*);

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;
  int unsigned cyc      = 0;
  logic [W-1:0] cur_d   = '0;
  logic [W-1:0] last_q  = '0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  int unsigned  cyc_q[$];

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [2*W-1:0] recip_of(logic [W-1:0] d);
    logic [2*W:0] num;
    num = '0;
    num[2*W] = 1'b1;
    num = (num + {{(W+1){1'b0}}, d} - 1) / {{(W+1){1'b0}}, d};
    return num[2*W-1:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input bit ld, input logic [W-1:0] d, input bit v, input logic [W-1:0] n, input string tag);
    logic [2*W-1:0] c;
    @(negedge clk_i);
    recip_load_i = ld;
    if (ld) begin
      c = recip_of(d);
      recip_hi_i = c[2*W-1:W];
      recip_lo_i = c[W-1:0];
      cur_d = d;
    end
    in_valid_i = v;
    dividend_i = n;
    if (v) begin
      exp_q.push_back(n / cur_d);
      tag_q.push_back(tag);
      cyc_q.push_back(cyc);
    end
  endtask

  task automatic send(input logic [W-1:0] n, input string tag);
    drive(1'b0, '0, 1'b1, n, tag);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) drive(1'b0, '0, 1'b0, '0, "");
  endtask

  task automatic sweep(input logic [W-1:0] d);
    drive(1'b1, d, 1'b0, '0, "");
    idle(2);
    send('0, "R9");
    send('1, "R4");
    send('1 - 1, "R4");
    for (int k = 1; k <= 20; k++) send(d * k, "R1");
    for (int k = 1; k <= 20; k++) send(d * k - 1, "R1");
    for (int k = 0; k < 150; k++) send($urandom, "R3");
    idle(3);
    for (int k = 0; k < 30; k++) begin
      send($urandom, "R1");
      idle(k % 3);
    end
    idle(4);
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (out_valid_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected output", quotient_o, '0);
        end else begin
          logic [W-1:0] e;
          string t;
          int unsigned c0;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          c0 = cyc_q.pop_front();
          chk(quotient_o == e, t, quotient_o, e);
          chk(cyc - c0 == 3, "R2 latency", W'(cyc - c0), W'(3));
        end
      end else begin
        chk(quotient_o == last_q, "R8 hold", quotient_o, last_q);
      end
      last_q = quotient_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R7 valid after reset", W'(out_valid_o), '0);
    chk(quotient_o == '0, "R7 quotient after reset", quotient_o, '0);

    sweep(7);
    sweep(10);
    sweep(3);
    sweep(2);
    sweep('1);
    sweep(32'd1000003);

    // load together with an issue, older dividends in flight (R5)
    drive(1'b1, 10, 1'b0, '0, "");
    for (int k = 0; k < 3; k++) send($urandom, "R5 old divisor");
    drive(1'b1, 7, 1'b1, 32'hFFFF_FFF0, "R5 same-cycle load");
    for (int k = 0; k < 3; k++) send($urandom, "R5 new divisor");
    drive(1'b1, 13, 1'b1, 32'd91, "R5 same-cycle load");
    send('1, "R5 new divisor");
    // long quiet stretch with load low, reciprocal must persist (R6)
    idle(40);
    for (int k = 0; k < 10; k++) send($urandom, "R6 held reciprocal");
    idle(6);

    chk(exp_q.size() == 0, "R2 all results returned", W'(exp_q.size()), '0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule